// File: doc/BRIEF.md
# Scancode Queue with Overrun Marker

This block is a short byte queue between a key-matrix scanner and the serial link that sends codes to the host. The scanner pushes one code byte at a time. The link reads the oldest byte at the head whenever the queue is not empty. The link pops the head only once that byte has gone out in full, so a transfer that is aborted can be retried with the same byte. On a pop, every remaining entry moves one slot toward the head.

The store has seventeen slots. Sixteen of them hold ordinary codes. The seventeenth is kept back for an overrun marker: a push that would land there stores 0xFF in place of the supplied byte. Once that slot is filled, further pushes are discarded until a pop frees space. A self-test completion byte is pushed like any other code. A fill level and an overrun indication are brought out so the queue state can be observed.

Top module: `scan_code_queue`

## Requirements
- R1: After reset the queue is empty: `fillLevel` is 0, `notEmpty` is 0 and `overrunActive` is 0.
- R2: A push while `fillLevel` is below 16 appends `pushByte` at the tail, and `fillLevel` rises by 1. `headByte` always shows the oldest stored entry.
- R3: A push while `fillLevel` is 16 stores the value 0xFF in the seventeenth slot, whatever `pushByte` holds. `fillLevel` becomes 17 and `overrunActive` reads 1 while that slot is occupied.
- R4: A push with no pop while `fillLevel` is 17 is discarded. `fillLevel` and all stored entries stay unchanged.
- R5: A pop on a non-empty queue removes the head and moves every remaining entry one slot toward the head, in order. `fillLevel` falls by 1.
- R6: Popping the last entry clears `notEmpty` and sets `fillLevel` to 0. The next push lands in the head slot.
- R7: A push and a pop in the same cycle on a non-empty queue do both, and `fillLevel` stays the same. The new byte goes to the tail after the shift. When `fillLevel` was 17, that tail is the reserved slot, so it takes 0xFF.
- R8: A pop on an empty queue is ignored. A push and a pop together on an empty queue act as a plain push.
- R9: Reading `headByte` never removes it: with neither strobe active, the head and `fillLevel` hold for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| pushReq | input | 1 | Push strobe from the scanner |
| pushByte | input | 8 | Code byte to push |
| popReq | input | 1 | Pop strobe after a completed transmit |
| headByte | output | 8 | Oldest stored entry |
| notEmpty | output | 1 | At least one entry is stored |
| fillLevel | output | 5 | Number of stored entries, 0 to 17 |
| overrunActive | output | 1 | The reserved slot holds the overrun marker |

## Verification
The bench targets these corner cases:
- The push at a fill level of 16 must store 0xFF. A design that stores the real byte there would send the host a bogus key instead of the overrun code.
- The push into a full queue must leave the queue untouched. A design that wraps or overwrites would corrupt entries, which shows up when the queue is drained in order.
- A simultaneous push and pop at full must place the marker again, not the data byte.
- A pop on an empty queue must not underflow the fill level. A design that underflows would report a huge fill level or a stale head.
- After the queue drains, the first push must appear at the head. A write pointer that is not reset to the base slot would place it elsewhere.

// File: rtl/scanq_pkg.sv
package scanq_pkg;
  // Strobes from the control half to the slot store
  typedef struct packed {
    logic shift;      // move every entry one slot toward the head
    logic write;      // store a byte at the slot given by wrIdx
    logic useMarker;  // store the overrun code instead of the pushed byte
  } scanq_strobe_t;
endpackage

// File: rtl/scanq_ctrl.sv
module scanq_ctrl
  import scanq_pkg::*;
#(
  parameter int REG_SLOTS = 16,
  localparam int TOTAL = REG_SLOTS + 1,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  output scanq_strobe_t    strobes,
  output logic [CNT_W-1:0] wrIdx,
  output logic [CNT_W-1:0] countQ
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] MARK_IDX = CNT_W'(REG_SLOTS);

  logic doPop, doPush;

  always_comb begin
    doPop  = popReq && (countQ != '0);
    doPush = pushReq && ((countQ != FULL_CNT) || doPop);
    wrIdx  = countQ - CNT_W'(doPop);
    strobes.shift     = doPop;
    strobes.write     = doPush;
    strobes.useMarker = (wrIdx == MARK_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= '0;
    else       countQ <= countQ + CNT_W'(doPush) - CNT_W'(doPop);
  end

  // R1: fill level never exceeds the slot count
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= FULL_CNT);
  // R4: push into a full queue with no pop changes nothing
  a_r4_full_push_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == FULL_CNT && pushReq && !popReq) |=> countQ == FULL_CNT);
  // R5: a lone pop lowers the fill level by one
  a_r5_pop_dec: assert property (@(posedge clk) disable iff (!rstN)
    (countQ != '0 && popReq && !pushReq) |=> countQ == $past(countQ) - 1'b1);
  // R7: push and pop together keep the fill level
  a_r7_pushpop_level: assert property (@(posedge clk) disable iff (!rstN)
    (countQ != '0 && popReq && pushReq) |=> $stable(countQ));
  // R8: pop on empty keeps the queue empty
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == '0 && popReq && !pushReq) |=> countQ == '0);
endmodule

// File: rtl/scanq_store.sv
module scanq_store
  import scanq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_SLOTS = 16,
  parameter logic [DATA_W-1:0] OVR_CODE = '1,
  localparam int TOTAL = REG_SLOTS + 1,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanq_strobe_t     strobes,
  input  logic [CNT_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] pushByte,
  output logic [DATA_W-1:0] headByte
);
  logic [DATA_W-1:0] slotQ [TOTAL];
  logic [DATA_W-1:0] slotD [TOTAL];

  always_comb begin
    for (int i = 0; i < TOTAL; i++) begin
      if (strobes.shift) slotD[i] = (i == TOTAL - 1) ? '0 : slotQ[(i + 1) % TOTAL];
      else               slotD[i] = slotQ[i];
      if (strobes.write && int'(wrIdx) == i)
        slotD[i] = strobes.useMarker ? OVR_CODE : pushByte;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < TOTAL; i++) begin
      if (!rstN) slotQ[i] <= '0;
      else       slotQ[i] <= slotD[i];
    end
  end

  assign headByte = slotQ[0];

  // R3: a marker write leaves the overrun code in the reserved slot
  a_r3_marker_stored: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.write && strobes.useMarker) |=> slotQ[REG_SLOTS] == OVR_CODE);
  // R5: a pop without a head write moves the second entry to the head
  a_r5_shift_head: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && !(strobes.write && wrIdx == '0)) |=> headByte == $past(slotQ[1]));
  // R9: with no strobe the head holds
  a_r9_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.shift && !strobes.write) |=> $stable(headByte));
endmodule

// File: rtl/scan_code_queue.sv
module scan_code_queue
  import scanq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_SLOTS = 16,
  parameter logic [DATA_W-1:0] OVR_CODE = '1,
  localparam int TOTAL = REG_SLOTS + 1,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic [DATA_W-1:0] pushByte,
  input  logic              popReq,
  output logic [DATA_W-1:0] headByte,
  output logic              notEmpty,
  output logic [CNT_W-1:0]  fillLevel,
  output logic              overrunActive
);
  scanq_strobe_t    strobes;
  logic [CNT_W-1:0] wrIdx;

  scanq_ctrl #(.REG_SLOTS(REG_SLOTS)) uCtrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .strobes(strobes), .wrIdx(wrIdx), .countQ(fillLevel)
  );

  scanq_store #(.DATA_W(DATA_W), .REG_SLOTS(REG_SLOTS), .OVR_CODE(OVR_CODE)) uStore (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx),
    .pushByte(pushByte), .headByte(headByte)
  );

  assign notEmpty      = (fillLevel != '0);
  assign overrunActive = (fillLevel == CNT_W'(TOTAL));

  // R6: popping the only entry empties the queue
  a_r6_last_pop: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == CNT_W'(1) && popReq && !pushReq) |=> !notEmpty);
  // R2: a push below the marker level stores the supplied byte at an empty head
  a_r2_first_push: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == '0 && pushReq) |=> headByte == $past(pushByte));
endmodule

// File: tb/tb_scan_code_queue.sv
module tb_scan_code_queue;
  logic       clk = 0;
  logic       rstN = 0;
  logic       pushReq = 0, popReq = 0;
  logic [7:0] pushByte = '0;
  logic [7:0] headByte;
  logic       notEmpty, overrunActive;
  logic [4:0] fillLevel;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scan_code_queue dut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .pushByte(pushByte),
    .popReq(popReq), .headByte(headByte), .notEmpty(notEmpty),
    .fillLevel(fillLevel), .overrunActive(overrunActive)
  );

  // {push, pop, data[7:0], expLevel[4:0], expHead[7:0], expOvr}
  localparam int NVEC = 9;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'h11, 5'd1, 8'h11, 1'b0},  // R2 first push
    {1'b1, 1'b0, 8'h22, 5'd2, 8'h11, 1'b0},  // R2 head stays oldest
    {1'b0, 1'b0, 8'h99, 5'd2, 8'h11, 1'b0},  // R9 idle, head held
    {1'b0, 1'b1, 8'h00, 5'd1, 8'h22, 1'b0},  // R5 pop shifts
    {1'b1, 1'b1, 8'h33, 5'd1, 8'h33, 1'b0},  // R7 push+pop
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h00, 1'b0},  // R6 last pop
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h00, 1'b0},  // R8 pop on empty
    {1'b1, 1'b1, 8'h44, 5'd1, 8'h44, 1'b0},  // R8 push+pop on empty
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h00, 1'b0}   // R6 empty again
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic pu, input logic po, input logic [7:0] d);
    @(negedge clk);
    pushReq = pu; popReq = po; pushByte = d;
    @(posedge clk);
    #1;
    pushReq = 0; popReq = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    #1;
    chk("R1 level", fillLevel, 0);
    chk("R1 notEmpty", notEmpty, 0);
    chk("R1 overrun", overrunActive, 0);

    for (int v = 0; v < NVEC; v++) begin
      step(VEC[v][23], VEC[v][22], VEC[v][21:14]);
      chk($sformatf("vec%0d level", v), fillLevel, VEC[v][13:9]);
      chk($sformatf("vec%0d notEmpty", v), notEmpty, VEC[v][13:9] != 0);
      chk($sformatf("vec%0d overrun", v), overrunActive, VEC[v][0]);
      if (VEC[v][13:9] != 0) chk($sformatf("vec%0d head", v), headByte, VEC[v][8:1]);
    end

    // R2: fill all regular slots
    for (int k = 1; k <= 16; k++) step(1, 0, 8'(k));
    chk("R2 level16", fillLevel, 16);
    chk("R2 head", headByte, 8'h01);
    chk("R2 no overrun", overrunActive, 0);

    // R3: push at level 16 becomes the marker
    step(1, 0, 8'hAB);
    chk("R3 level17", fillLevel, 17);
    chk("R3 overrun", overrunActive, 1);

    // R4: push into full queue is dropped
    step(1, 0, 8'hCD);
    chk("R4 level", fillLevel, 17);
    chk("R4 head", headByte, 8'h01);

    // R7: push+pop at full puts the marker in the tail again
    step(1, 1, 8'h55);
    chk("R7 level", fillLevel, 17);
    chk("R7 head", headByte, 8'h02);

    // R5: drain, contents must be 02..10, FF, FF
    for (int k = 2; k <= 16; k++) begin
      chk("R5 drain order", headByte, k);
      step(0, 1, 8'h00);
    end
    chk("R3 marker value", headByte, 8'hFF);
    step(0, 1, 8'h00);
    chk("R7 marker value", headByte, 8'hFF);
    chk("R5 level1", fillLevel, 1);
    step(0, 1, 8'h00);
    chk("R6 level0", fillLevel, 0);
    chk("R6 notEmpty", notEmpty, 0);

    // R6: next push lands at the head
    step(1, 0, 8'h77);
    chk("R6 base slot", headByte, 8'h77);
    chk("R6 level", fillLevel, 1);

    // R9: head held over idle cycles
    repeat (5) step(0, 0, 8'h00);
    chk("R9 head held", headByte, 8'h77);
    chk("R9 level held", fillLevel, 1);

    // R1: reset mid-run empties the queue
    @(negedge clk) rstN = 0;
    @(posedge clk); #1;
    @(negedge clk) rstN = 1;
    #1;
    chk("R1 reset level", fillLevel, 0);
    chk("R1 reset notEmpty", notEmpty, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule